// File: doc/BRIEF.md
# Reset Mode Select and Bootstrap Loader

This block decides how the core starts after reset. Two mode-select pins are captured into a register while reset is held and decoded into one of four start-up modes. In the two normal modes, and in the test mode, the core is released one cycle after reset deasserts with a fixed start address of 0xE000. In bootstrap mode the core is held while a fixed-length program of 256 bytes arrives on a byte-wide valid/data receive stream. Each byte is written into on-chip RAM through a simple write port at consecutive addresses from 0x0000, and the core is then released with a start address of 0x0000.

The captured mode is also driven out, so that neighbouring blocks can switch their port functions to match. A separate enable tells the pin logic whether the external address/data bus may be used. The sequencer has three named states. ST_HOLD is entered and kept while reset is low. On the first edge with reset high, ST_HOLD goes to ST_LOAD when the captured mode is bootstrap, and to ST_RUN in every other mode. ST_LOAD stays put until the byte that completes the program is accepted, then goes to ST_RUN. ST_RUN holds until the next reset. A low reset sends every state back to ST_HOLD.

Top module: `boot_mode_loader`

## Requirements
- R1: The `mode` output equals {mode_pin_a, mode_pin_b} as captured. 2'b00 is bootstrap, 2'b01 is single-chip, 2'b11 is expanded, and 2'b10 is test.
- R2: The pins are captured on every rising clock edge while `rst_n` is low, so the value present at the last edge of reset is kept. Pin changes while `rst_n` is high have no effect on `mode` until the next reset.
- R3: In single-chip, expanded and test modes, `core_run` is low in the cycle in which `rst_n` is released. It rises after the first rising edge with `rst_n` high, and `start_addr` reads 0xE000.
- R4: In bootstrap mode, before the core runs, every cycle with `rx_valid` high drives `ram_we` high in that same cycle. In that cycle `ram_wdata` equals `rx_data` and `ram_addr` equals the number of bytes already stored, starting from 0.
- R5: In bootstrap mode, `core_run` stays low until the 256th byte has been written. It is high from the cycle after that write, and `start_addr` then reads 0x0000.
- R6: Once `core_run` is high, `rx_valid` is ignored: `ram_we` stays low.
- R7: Once high, `core_run` stays high until the next reset.
- R8: A low `rst_n`, sampled synchronously, forces `core_run` and `ram_we` low. Reset during a download restarts the byte count, so the next byte goes to address 0.
- R9: `ext_bus_en` is high in expanded and test modes and low in single-chip and bootstrap modes.
- R10: Cycles without `rx_valid` during a download leave `ram_we` low and `ram_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pin_a | input | 1 | First mode-select pin (upper bit of mode) |
| mode_pin_b | input | 1 | Second mode-select pin (lower bit of mode) |
| rx_valid | input | 1 | Received byte is valid this cycle |
| rx_data | input | 8 | Received byte |
| ram_we | output | 1 | RAM write strobe, one cycle per stored byte |
| ram_addr | output | 8 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| start_addr | output | 16 | Address the core begins executing from |
| core_run | output | 1 | Core may run |
| mode | output | 2 | Captured start-up mode |
| ext_bus_en | output | 1 | External address/data bus allowed |

## Verification
Some internal faults show up at the ports with no delay. A byte counter that skips or repeats a value is seen in the very next write cycle, because `ram_addr` no longer matches the count of bytes sent. A wrong done condition shows up at the 256th byte: the release comes one byte early or late, or never comes. A wrong state after reset shows up one edge after release, either as `core_run` rising in bootstrap mode or staying low in the other modes. A mode register that follows the pins after reset shows up on `mode` and `ext_bus_en` one edge after the pins change.

// File: rtl/bml_pkg.sv
package bml_pkg;

    // Encoding is {mode_pin_a, mode_pin_b}; the bit positions are part of the behaviour.
    typedef enum logic [1:0] {
        MODE_BOOT     = 2'b00,
        MODE_SINGLE   = 2'b01,
        MODE_TEST     = 2'b10,
        MODE_EXPANDED = 2'b11
    } boot_mode_e;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } ldr_state_e;

endpackage

// File: rtl/bml_mode_latch.sv
module bml_mode_latch
    import bml_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_a,
    input  logic       pin_b,
    output boot_mode_e mode_q
);

    // Follows the pins throughout reset; frozen once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= boot_mode_e'({pin_a, pin_b});
        end
    end

endmodule

// File: rtl/bml_loader_fsm.sv
module bml_loader_fsm
    import bml_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LOAD_BYTES = 256,
    localparam int RAM_AW    = $clog2(LOAD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  boot_mode_e        mode,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              core_run
);

    localparam logic [RAM_AW-1:0] LAST_IDX = RAM_AW'(LOAD_BYTES - 1);

    ldr_state_e        state_q, state_d;
    logic [RAM_AW-1:0] cnt_q;
    logic              take;

    assign take = (state_q == ST_LOAD) && rx_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Byte counter: clears in reset, advances on each accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = (mode == MODE_BOOT) ? ST_LOAD : ST_RUN;
            ST_LOAD: if (take && (cnt_q == LAST_IDX)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    // Outputs
    always_comb begin
        ram_we    = 1'b0;
        core_run  = 1'b0;
        ram_addr  = cnt_q;
        ram_wdata = rx_data;
        unique case (state_q)
            ST_HOLD: ;
            ST_LOAD: ram_we = rx_valid;
            ST_RUN:  core_run = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
    import bml_pkg::*;
#(
    parameter int              DATA_W       = 8,
    parameter int              LOAD_BYTES   = 256,
    parameter int              VEC_W        = 16,
    parameter logic [VEC_W-1:0] NORMAL_START = 16'hE000,
    parameter logic [VEC_W-1:0] LOAD_BASE    = 16'h0000,
    localparam int             RAM_AW       = $clog2(LOAD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pin_a,
    input  logic              mode_pin_b,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [VEC_W-1:0]  start_addr,
    output logic              core_run,
    output logic [1:0]        mode,
    output logic              ext_bus_en
);

    boot_mode_e mode_q;

    bml_mode_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_a  (mode_pin_a),
        .pin_b  (mode_pin_b),
        .mode_q (mode_q)
    );

    bml_loader_fsm #(
        .DATA_W     (DATA_W),
        .LOAD_BYTES (LOAD_BYTES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .core_run  (core_run)
    );

    always_comb begin
        start_addr = NORMAL_START;
        ext_bus_en = 1'b0;
        unique case (mode_q)
            MODE_BOOT:     start_addr = LOAD_BASE;
            MODE_SINGLE:   ext_bus_en = 1'b0;
            MODE_EXPANDED: ext_bus_en = 1'b1;
            MODE_TEST:     ext_bus_en = 1'b1;
            default:       ext_bus_en = 1'b0;
        endcase
    end

    assign mode = mode_q;

endmodule

// File: rtl/bml_checker.sv
module bml_checker
    import bml_pkg::*;
#(
    parameter int               LOAD_BYTES   = 256,
    parameter int               VEC_W        = 16,
    parameter logic [VEC_W-1:0] NORMAL_START = 16'hE000,
    parameter logic [VEC_W-1:0] LOAD_BASE    = 16'h0000,
    parameter int               RAM_AW       = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_addr,
    input logic [VEC_W-1:0]  start_addr,
    input logic              core_run,
    input logic [1:0]        mode,
    input logic              ext_bus_en
);

    logic [RAM_AW:0] wr_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen <= '0;
        end else if (ram_we) begin
            wr_seen <= wr_seen + 1'b1;
        end
    end

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode)); // R2

    AST_NORMAL_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && mode != MODE_BOOT) |-> start_addr == NORMAL_START); // R3

    AST_WE_BOOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> mode == MODE_BOOT); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> ram_addr == RAM_AW'($past(ram_addr) + 1'b1)); // R4

    AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && mode == MODE_BOOT) |-> (wr_seen == (RAM_AW+1)'(LOAD_BYTES) && start_addr == LOAD_BASE)); // R5

    AST_NO_WRITE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !core_run); // R6

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        core_run |=> core_run); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!core_run && !ram_we)); // R8

    AST_BUS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_bus_en == mode[1]); // R9

endmodule

bind boot_mode_loader bml_checker #(
    .LOAD_BYTES   (LOAD_BYTES),
    .VEC_W        (VEC_W),
    .NORMAL_START (NORMAL_START),
    .LOAD_BASE    (LOAD_BASE),
    .RAM_AW       (RAM_AW)
) u_bml_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .start_addr (start_addr),
    .core_run   (core_run),
    .mode       (mode),
    .ext_bus_en (ext_bus_en)
);

// File: tb/tb_boot_mode_loader.sv
module tb_boot_mode_loader;

    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_pin_a = 1'b0;
    logic        mode_pin_b = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        ram_we;
    logic [7:0]  ram_addr;
    logic [7:0]  ram_wdata;
    logic [15:0] start_addr;
    logic        core_run;
    logic [1:0]  mode;
    logic        ext_bus_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_mode_loader dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_pin_a (mode_pin_a),
        .mode_pin_b (mode_pin_b),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .start_addr (start_addr),
        .core_run   (core_run),
        .mode       (mode),
        .ext_bus_en (ext_bus_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Hold reset for three edges with the given pins; return at a negedge with rst_n released.
    task automatic do_reset(input logic a, input logic b);
        @(negedge clk);
        rst_n = 1'b0; rx_valid = 1'b0;
        mode_pin_a = ~a; mode_pin_b = ~b;
        @(negedge clk);
        mode_pin_a = a; mode_pin_b = b;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 mode decode", 32'(mode), 32'({a, b}));
        chk("R2 capture in reset", 32'(mode), 32'({a, b}));
        chk("R8 run low in reset", 32'(core_run), 0);
        chk("R8 we low in reset", 32'(ram_we), 0);
        chk("R9 bus enable", 32'(ext_bus_en), 32'(a));
        rst_n = 1'b1;
        #1;
        chk("R3 run low at release", 32'(core_run), 0);
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 7 + seed * 13 + 3) & 255);
    endfunction

    task automatic send_byte(input int idx, input int seed, input string req);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = pat(idx, seed);
        #1;
        chk({req, " we"}, 32'(ram_we), 1);
        chk({req, " addr"}, 32'(ram_addr), 32'(idx & 255));
        chk("R4 data", 32'(ram_wdata), 32'(pat(idx, seed)));
        chk("R5 held during load", 32'(core_run), 0);
    endtask

    task automatic gap(input int idx);
        @(negedge clk);
        rx_valid = 1'b0; rx_data = 8'hA5;
        #1;
        chk("R10 gap no we", 32'(ram_we), 0);
        chk("R10 gap addr", 32'(ram_addr), 32'(idx & 255));
    endtask

    initial begin : main
        // Normal and test modes
        for (int m = 1; m < 4; m++) begin
            logic a, b;
            a = m[1]; b = m[0];
            do_reset(a, b);
            @(negedge clk);
            #1;
            chk("R3 run after release", 32'(core_run), 1);
            chk("R3 start addr", 32'(start_addr), 32'h0000E000);
            mode_pin_a = ~a; mode_pin_b = ~b;
            rx_valid = 1'b1;
            repeat (3) @(negedge clk);
            #1;
            chk("R2 mode frozen", 32'(mode), 32'({a, b}));
            chk("R9 bus after pin change", 32'(ext_bus_en), 32'(a));
            chk("R6 no write in normal mode", 32'(ram_we), 0);
            chk("R7 run stays", 32'(core_run), 1);
            rx_valid = 1'b0;
        end

        // Full download with gaps
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < NBYTES; i++) begin
            send_byte(i, 1, "R4");
            if (i % 3 == 2) gap(i + 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
        chk("R5 run after 256th", 32'(core_run), 1);
        chk("R5 start addr boot", 32'(start_addr), 0);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h3C;
        #1;
        chk("R6 extra byte ignored", 32'(ram_we), 0);
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
        chk("R7 run stays after extra", 32'(core_run), 1);

        // Reset in mid-download, then a full reload
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 100; i++) send_byte(i, 2, "R4 partial");
        do_reset(1'b0, 1'b0);
        send_byte(0, 3, "R8 restart");
        for (int i = 1; i < NBYTES; i++) send_byte(i, 3, "R4 reload");
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
        chk("R5 run after reload", 32'(core_run), 1);
        chk("R9 boot no bus", 32'(ext_bus_en), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule